// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the command interface of a NOR-style flash bank, limited to erase. It watches the bank's write cycles and recognises the six-write sequences that request a whole-bank erase or a sector erase. A sector erase opens a collection window. Further sector-erase writes that arrive inside that window add their sectors to an erase buffer and restart the window. When the window runs out, a modelled erase engine takes over. It first pre-programs the chosen sectors to zero and verifies them, then erases them. When it finishes, the bank returns to read mode.

Status is reported on plain pins. There is a ready line, a bit that flips on every status read while the bank is busy, and a bit that shows the collection window has closed and the erase is running. A request for an identification or query access is granted only while the bank is idle. The active-low reset aborts any operation at once.

Write cycles arrive as single-cycle strobes with no back-pressure. The block samples every write on the clock edge where `wr_en` is high, and it never stalls the writer. A write that has no meaning in the current state is dropped or handled as the requirements below state.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `phase` is 0, `sect_buf` is all zeros, `rdy` is 1, `tgl` is 0 and `tmr_bit` is 0.
- R2: The write sequence 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10 starts a bank erase with no window. After the last write, `phase` is 2 and `sect_buf` is all ones. Only the low `ADDR_W-SECT_W` address bits are compared.
- R3: The same five leading writes, followed by data 0x30 at any address, open the window. After that write, `phase` is 1 and `sect_buf` holds a one-hot bit at the sector index taken from address bits [ADDR_W-1 : ADDR_W-SECT_W].
- R4: The window lasts `WINDOW_CYC` cycles after the last accepted 0x30 write. Each 0x30 write inside the window ORs its sector into `sect_buf` and restarts the window.
- R5: Inside the window, a write with data 0xB0 (suspend) is ignored: the window keeps running and `sect_buf` is kept. Any other data except 0x30 clears `sect_buf` and returns `phase` to 0.
- R6: A wrong write anywhere in the first five cycles, or a wrong sixth cycle, returns the decoder to read mode. The cycles that follow must then start a new sequence from the beginning.
- R7: The engine stays in `phase` 2 (pre-program and verify) for `PRE_CYC` cycles and then in `phase` 3 (erase) for `ERS_CYC` cycles. It then returns to `phase` 0, and `sect_buf` is cleared.
- R8: Every write during `phase` 2 or 3 is ignored, and no partial sequence is kept afterwards.
- R9: `rdy` is 0 while `phase` is non-zero. `tmr_bit` is 1 exactly while `phase` is 2 or 3.
- R10: `tgl` inverts on each cycle in which `stat_rd` is high while `rdy` is 0. Otherwise it holds.
- R11: `aux_grant` equals `aux_req` while `phase` is 0 and is 0 otherwise.
- R12: Driving `rst_n` low aborts any window or erase at once and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address; the top SECT_W bits are the sector index |
| wr_data | input | 8 | Write data (command code) |
| stat_rd | input | 1 | Status read strobe |
| aux_req | input | 1 | Identification/query access request |
| rdy | output | 1 | 1 = ready, 0 = busy |
| tgl | output | 1 | Toggle bit |
| tmr_bit | output | 1 | Window closed, erase running |
| phase | output | 2 | 0 idle, 1 window, 2 pre-program/verify, 3 erase |
| sect_buf | output | 2**SECT_W | Sectors selected for erase |
| aux_grant | output | 1 | Identification/query access granted |

## Verification
A write sampled on edge k updates `phase` and `sect_buf` in the same edge's register update. The bench therefore checks them on the falling edge that ends the write task. Window expiry is due `WINDOW_CYC` edges after the last accepted 0x30 write. The pre-program phase then lasts `PRE_CYC` edges and erase lasts `ERS_CYC` edges. Each boundary is checked one cycle before it, where the old phase must still hold, and again on it, where the new phase must appear. The toggle bit is checked on the falling edge after the status-read edge, and reset is checked one time unit after `rst_n` falls, because that reset is asynchronous.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WIN   = 2'd1,
    PH_PREP  = 2'd2,
    PH_ERASE = 2'd3
  } phase_e;

  localparam logic [10:0] A_UNLK1 = 11'h555;
  localparam logic [10:0] A_UNLK2 = 11'h2AA;
  localparam logic [7:0]  D_UNLK1 = 8'hAA;
  localparam logic [7:0]  D_UNLK2 = 8'h55;
  localparam logic [7:0]  D_SETUP = 8'h80;
  localparam logic [7:0]  D_CHIP  = 8'h10;
  localparam logic [7:0]  D_SECT  = 8'h30;
  localparam logic [7:0]  D_SUSP  = 8'hB0;
endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
  import fes_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SECT_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              is_ul1,
  output logic              is_ul2,
  output logic              is_setup,
  output logic              is_chip,
  output logic              is_sect,
  output logic              is_susp,
  output logic [SECT_W-1:0] sect
);
  localparam int LOW_W = ADDR_W - SECT_W;

  logic [LOW_W-1:0] low;
  logic             at_a1, at_a2;

  assign low   = addr[LOW_W-1:0];
  assign sect  = addr[ADDR_W-1 -: SECT_W];
  assign at_a1 = (low == LOW_W'(A_UNLK1));
  assign at_a2 = (low == LOW_W'(A_UNLK2));

  assign is_ul1   = at_a1 && (data == D_UNLK1);
  assign is_ul2   = at_a2 && (data == D_UNLK2);
  assign is_setup = at_a1 && (data == D_SETUP);
  assign is_chip  = at_a1 && (data == D_CHIP);
  assign is_sect  = (data == D_SECT);
  assign is_susp  = (data == D_SUSP);
endmodule

// File: rtl/fes_win_timer.sv
module fes_win_timer #(
  parameter int LIMIT = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + CW'(1);
  end

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !expired) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/fes_erase_engine.sv
module fes_erase_engine
  import fes_pkg::*;
#(
  parameter int PRE_CYC = 16,
  parameter int ERS_CYC = 32
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e ph,
  output logic   done
);
  localparam int MAXC = (PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign done = (ph == PH_ERASE) && (cnt == CW'(ERS_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_PREP;
          cnt <= '0;
        end
        PH_PREP: if (cnt == CW'(PRE_CYC - 1)) begin
          ph  <= PH_ERASE;
          cnt <= '0;
        end else cnt <= cnt + CW'(1);
        PH_ERASE: if (done) begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end else cnt <= cnt + CW'(1);
        default: begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assert_engine_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && !start) |=> (ph == PH_IDLE));

  assert_prep_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PREP) |=> (ph == PH_PREP || ph == PH_ERASE));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ph == PH_IDLE));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int SECT_W     = 3,
  parameter int WINDOW_CYC = 80,
  parameter int PRE_CYC    = 16,
  parameter int ERS_CYC    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   stat_rd,
  input  logic                   aux_req,
  output logic                   rdy,
  output logic                   tgl,
  output logic                   tmr_bit,
  output logic [1:0]             phase,
  output logic [(1<<SECT_W)-1:0] sect_buf,
  output logic                   aux_grant
);
  localparam int NUM_SECT = 1 << SECT_W;

  typedef enum logic [2:0] {
    S_RD, S_U1, S_U2, S_SET, S_U3, S_U4, S_WIN, S_BUSY
  } st_e;

  st_e                st;
  logic               is_ul1, is_ul2, is_setup, is_chip, is_sect, is_susp;
  logic [SECT_W-1:0]  sect;
  logic [NUM_SECT-1:0] onehot;
  logic               win_clear, win_exp, eng_start, eng_done;
  phase_e             eng_ph, ph_now;

  fes_cmd_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) dec_i (
    .addr(wr_addr), .data(wr_data),
    .is_ul1(is_ul1), .is_ul2(is_ul2), .is_setup(is_setup),
    .is_chip(is_chip), .is_sect(is_sect), .is_susp(is_susp), .sect(sect)
  );

  assign onehot    = NUM_SECT'(1) << sect;
  assign win_clear = wr_en && is_sect && (st == S_U4 || st == S_WIN);
  assign eng_start = (st == S_U4 && wr_en && is_chip) ||
                     (st == S_WIN && !wr_en && win_exp);

  fes_win_timer #(.LIMIT(WINDOW_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clear(win_clear),
    .run(st == S_WIN), .expired(win_exp)
  );

  fes_erase_engine #(.PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .ph(eng_ph), .done(eng_done)
  );

  always_comb begin
    case (st)
      S_WIN:   ph_now = PH_WIN;
      S_BUSY:  ph_now = eng_ph;
      default: ph_now = PH_IDLE;
    endcase
  end

  assign phase     = ph_now;
  assign rdy       = (ph_now == PH_IDLE);
  assign tmr_bit   = (st == S_BUSY);
  assign aux_grant = aux_req && rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RD;
      sect_buf <= '0;
      tgl      <= 1'b0;
    end else begin
      if (stat_rd && !rdy) tgl <= ~tgl;
      case (st)
        S_RD:  if (wr_en && is_ul1) st <= S_U1;
        S_U1:  if (wr_en) st <= is_ul2   ? S_U2  : S_RD;
        S_U2:  if (wr_en) st <= is_setup ? S_SET : S_RD;
        S_SET: if (wr_en) st <= is_ul1   ? S_U3  : S_RD;
        S_U3:  if (wr_en) st <= is_ul2   ? S_U4  : S_RD;
        S_U4: if (wr_en) begin
          if (is_chip) begin
            st       <= S_BUSY;
            sect_buf <= '1;
          end else if (is_sect) begin
            st       <= S_WIN;
            sect_buf <= onehot;
          end else st <= S_RD;
        end
        S_WIN: if (wr_en) begin
          if (is_sect) sect_buf <= sect_buf | onehot;
          else if (!is_susp) begin
            st       <= S_RD;
            sect_buf <= '0;
          end
        end else if (win_exp) st <= S_BUSY;
        S_BUSY: if (eng_done) begin
          st       <= S_RD;
          sect_buf <= '0;
        end
        default: st <= S_RD;
      endcase
    end
  end

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && wr_en && !eng_done) |=> (st == S_BUSY && $stable(sect_buf)));

  assert_win_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && wr_en && !is_sect && !is_susp) |=> (st == S_RD && sect_buf == '0));

  assert_sect_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && wr_en && is_sect) |=>
      (st == S_WIN && sect_buf == ($past(sect_buf) | $past(onehot))));

  assert_tgl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> $stable(tgl));

  assert_engine_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY) |-> (eng_ph == PH_PREP || eng_ph == PH_ERASE));
endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 14;
  localparam int SW  = 3;
  localparam int WIN = 10;
  localparam int PRE = 6;
  localparam int ERS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          stat_rd = 1'b0;
  logic          aux_req = 1'b0;
  logic          rdy, tgl, tmr_bit, aux_grant;
  logic [1:0]    phase;
  logic [7:0]    sect_buf;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .SECT_W(SW), .WINDOW_CYC(WIN),
                    .PRE_CYC(PRE), .ERS_CYC(ERS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat_rd(stat_rd), .aux_req(aux_req),
    .rdy(rdy), .tgl(tgl), .tmr_bit(tmr_bit), .phase(phase),
    .sect_buf(sect_buf), .aux_grant(aux_grant)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic head5();
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h80);
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55);
  endtask

  task automatic sect_cmd(input logic [2:0] s);
    wr({s, 11'h000}, 8'h30);
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);   chk("R1 buf", sect_buf, 0);
    chk("R1 rdy", rdy, 1);       chk("R1 tgl", tgl, 0);
    chk("R1 tmr", tmr_bit, 0);
  endtask

  task automatic t_chip();
    head5(); wr(14'h0555, 8'h10);
    chk("R2 phase", phase, 2);   chk("R2 buf", sect_buf, 8'hFF);
    chk("R9 rdy", rdy, 0);       chk("R9 tmr", tmr_bit, 1);
    idle(PRE-1); chk("R7 prep hold", phase, 2);
    idle(1);     chk("R7 erase", phase, 3);
    idle(ERS-1); chk("R7 erase hold", phase, 3);
    idle(1);     chk("R7 idle", phase, 0);
    chk("R7 buf clr", sect_buf, 0); chk("R9 rdy back", rdy, 1);
    chk("R9 tmr off", tmr_bit, 0);
  endtask

  task automatic t_sector();
    head5(); sect_cmd(3'd2);
    chk("R3 phase", phase, 1);   chk("R3 buf", sect_buf, 8'h04);
    chk("R9 rdy win", rdy, 0);   chk("R9 tmr win", tmr_bit, 0);
    idle(5); sect_cmd(3'd5);
    chk("R4 add", sect_buf, 8'h24); chk("R4 phase", phase, 1);
    idle(WIN-1); chk("R4 restart", phase, 1);
    idle(1);     chk("R4 expire", phase, 2);
    chk("R4 buf kept", sect_buf, 8'h24); chk("R9 tmr run", tmr_bit, 1);
    idle(PRE+ERS); chk("R7 sector done", phase, 0);
  endtask

  task automatic t_abort();
    head5(); sect_cmd(3'd1); wr(14'h0555, 8'hF0);
    chk("R5 abort phase", phase, 0); chk("R5 abort buf", sect_buf, 0);
    chk("R5 abort rdy", rdy, 1);
    idle(WIN+2); chk("R5 no erase", phase, 0);
  endtask

  task automatic t_suspend();
    head5(); sect_cmd(3'd7); idle(3); wr(14'h0000, 8'hB0);
    chk("R5 susp phase", phase, 1); chk("R5 susp buf", sect_buf, 8'h80);
    idle(WIN); chk("R5 susp no restart", phase, 2);
    idle(PRE+ERS); chk("R5 susp done", phase, 0);
  endtask

  task automatic t_badseq();
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h90);
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h10);
    chk("R6 bad setup", phase, 0);
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h80);
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h00); sect_cmd(3'd4);
    chk("R6 bad unlock", phase, 0); chk("R6 buf", sect_buf, 0);
    head5(); wr(14'h0555, 8'h20);
    chk("R6 bad final", phase, 0);
    wr(14'h0555, 8'h10); chk("R6 no resume", phase, 0);
  endtask

  task automatic t_ignore();
    head5(); wr(14'h0555, 8'h10);
    head5();
    chk("R8 busy phase", phase, 3); chk("R8 busy buf", sect_buf, 8'hFF);
    idle(ERS); chk("R8 back idle", phase, 0);
    wr(14'h0555, 8'h10); chk("R8 no partial", phase, 0);
  endtask

  task automatic t_toggle();
    logic t0;
    t0 = tgl;
    rd_stat(); chk("R10 idle hold", tgl, t0);
    head5(); sect_cmd(3'd0);
    rd_stat(); chk("R10 flip1", tgl, !t0);
    rd_stat(); chk("R10 flip2", tgl, t0);
    idle(2);   chk("R10 hold", tgl, t0);
    wr(14'h0555, 8'hF0);
  endtask

  task automatic t_aux();
    aux_req = 1'b1; #1;
    chk("R11 grant idle", aux_grant, 1);
    head5(); sect_cmd(3'd6);
    chk("R11 refuse", aux_grant, 0);
    wr(14'h0555, 8'hF0); #1;
    chk("R11 grant again", aux_grant, 1);
    aux_req = 1'b0; #1;
    chk("R11 no req", aux_grant, 0);
  endtask

  task automatic t_hwreset();
    head5(); wr(14'h0555, 8'h10); rd_stat();
    idle(PRE+1); chk("R12 pre erase", phase, 3);
    rst_n = 1'b0; #1;
    chk("R12 phase", phase, 0); chk("R12 buf", sect_buf, 0);
    chk("R12 rdy", rdy, 1);     chk("R12 tgl", tgl, 0);
    chk("R12 tmr", tmr_bit, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2); chk("R12 stays idle", phase, 0);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    t_reset(); t_chip(); t_sector(); t_abort(); t_suspend();
    t_badseq(); t_ignore(); t_toggle(); t_aux(); t_hwreset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule